// File: doc/BRIEF.md
# SIMT Warp Reconvergence PC Stack

This block holds the program-counter state of every warp in one compute unit of a SIMT processor. Each warp owns a small stack whose entries carry a next PC, a reconvergence PC and a lane mask that marks the threads running on that entry. The fetch side names a warp. The block returns the PC and lane mask of that warp's top entry, and moves the top entry forward by one 64-bit instruction (8 bytes). An entry is removed once its advanced PC equals its reconvergence PC. The entry below it then takes over, with the wider lane mask it held before the split.

The branch unit reports a branch outcome as a lane mask of taken threads, together with a target and a reconvergence PC. If every active lane takes the branch, the top entry jumps. If none does, nothing changes. If the lanes split, the top entry is parked at the reconvergence PC. The fall-through path and then the taken path are pushed above it, and a path that would start at the reconvergence PC is not pushed. A warp is started by a launch that loads one entry, whose reconvergence PC serves as the end address. When that base entry pops, the stack is empty and the warp is finished.

Top module: `simt_pc_stack`

## Requirements
- R1: While reset is asserted, and until the first launch, no warp is live, no overflow flag is set and `fetch_valid` stays low.
- R2: A launch loads one entry (start PC, end PC, lane mask) for the named warp, replacing any previous contents, and sets its `warp_live` bit on the next cycle. The next fetch for that warp returns the start PC and that mask.
- R3: A fetch accepted at one clock edge gives `fetch_valid` high after that edge, with the top entry's PC, lane mask and warp ID. The top entry's PC then advances by 8.
- R4: A branch whose taken mask covers every lane of the top entry's mask replaces the top PC with the target and leaves the mask unchanged. A branch whose taken mask shares no lane with the top entry's mask has no effect.
- R5: A split branch parks the top entry at the reconvergence PC. It pushes the fall-through path (current top PC, lanes not taken) and then the taken path (target, lanes taken), so the taken path is fetched first.
- R6: When a split path's start PC equals the reconvergence PC, that path is not pushed.
- R7: A fetch whose advanced PC equals the top entry's reconvergence PC pops the top entry, and the next fetch is served by the entry below it.
- R8: A pop that empties the stack clears `warp_live`. After that, fetch requests for the warp produce no `fetch_valid`.
- R9: A split branch that would grow the stack beyond DEPTH entries leaves the stack unchanged and sets that warp's `stack_ovf` bit. The bit stays set until reset. A split that fills the stack exactly is accepted.
- R10: For one warp in one cycle, a launch overrides a branch and a fetch, and a branch overrides a fetch. An overridden fetch produces no `fetch_valid`.
- R11: Warps are independent: operations on one warp leave the PCs, masks and live state of the others unchanged.
- R12: A branch reported for a warp that is not live has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Start a warp |
| launch_warp | input | WID_W | Warp to start |
| launch_pc | input | PC_W | First instruction address |
| launch_end_pc | input | PC_W | End address; reaching it finishes the warp |
| launch_mask | input | LANES | Lanes active at start |
| fetch_req | input | 1 | Request the next instruction address of a warp |
| fetch_warp | input | WID_W | Warp being fetched |
| br_valid | input | 1 | Branch outcome present |
| br_warp | input | WID_W | Warp that executed the branch |
| br_target | input | PC_W | Branch target address |
| br_rpc | input | PC_W | Reconvergence address of the branch |
| br_taken | input | LANES | Lanes that take the branch |
| fetch_valid | output | 1 | Fetch address valid this cycle |
| fetch_pc | output | PC_W | Fetch address |
| fetch_wid | output | WID_W | Warp of the fetch address |
| fetch_mask | output | LANES | Active lanes of the fetched instruction |
| warp_live | output | NUM_WARPS | Per-warp live flag |
| stack_ovf | output | NUM_WARPS | Per-warp sticky stack overflow flag |

## Verification
The assertions assume that every launch mask has at least one lane set, so that any valid fetch carries a non-empty mask. The stimulus obeys this by always launching with non-zero masks, including in the pseudo-random phase. The stimulus is also the only source of any overlap between launch, branch and fetch. It drives same-warp collisions on purpose to exercise the priority order, and it keeps warp indices inside the configured warp count. Reconvergence addresses in the directed cases lie ahead of the paths that reach them. The random phase may create paths that never reconverge, and the reference model follows these exactly.

// File: rtl/simt_pcs_pkg.sv
package simt_pcs_pkg;

  // Instruction width in bytes; every fetch advances the PC by this amount.
  localparam int unsigned INSTR_BYTES = 8;

  // Classification of one branch outcome against the top entry.
  typedef enum logic [1:0] {
    BR_IGNORE  = 2'd0,
    BR_UNIFORM = 2'd1,
    BR_SPLIT   = 2'd2
  } br_kind_e;

endpackage

// File: rtl/simt_pcs_br_sort.sv
module simt_pcs_br_sort
  import simt_pcs_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PC_W  = 32
) (
  input  logic [LANES-1:0] top_mask,
  input  logic [PC_W-1:0]  top_pc,
  input  logic [LANES-1:0] taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_rpc,
  output br_kind_e         kind,
  output logic             push_nt,
  output logic             push_tk,
  output logic [1:0]       push_cnt,
  output logic [LANES-1:0] nt_mask,
  output logic [LANES-1:0] tk_mask
);

  always_comb begin
    tk_mask = top_mask & taken;
    nt_mask = top_mask & ~taken;
    if (tk_mask == '0) begin
      kind = BR_IGNORE;
    end else if (nt_mask == '0) begin
      kind = BR_UNIFORM;
    end else begin
      kind = BR_SPLIT;
    end
    // A path that would start at the reconvergence point is empty.
    push_nt  = (kind == BR_SPLIT) && (top_pc != br_rpc);
    push_tk  = (kind == BR_SPLIT) && (br_target != br_rpc);
    push_cnt = {1'b0, push_nt} + {1'b0, push_tk};
  end

endmodule

// File: rtl/simt_pcs_warp.sv
module simt_pcs_warp
  import simt_pcs_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_en,
  input  logic [PC_W-1:0]  launch_pc,
  input  logic [PC_W-1:0]  launch_end,
  input  logic [LANES-1:0] launch_mask,
  input  logic             br_en,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_rpc,
  input  logic [LANES-1:0] br_taken,
  input  logic             fetch_en,
  output logic [PC_W-1:0]  top_pc,
  output logic [LANES-1:0] top_mask,
  output logic             live,
  output logic             ovf
);

  localparam int SP_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  pc_q   [DEPTH];
  logic [PC_W-1:0]  pc_d   [DEPTH];
  logic [PC_W-1:0]  rpc_q  [DEPTH];
  logic [PC_W-1:0]  rpc_d  [DEPTH];
  logic [LANES-1:0] mask_q [DEPTH];
  logic [LANES-1:0] mask_d [DEPTH];
  logic [SP_W-1:0]  sp_q, sp_d;
  logic             ovf_q, ovf_d;

  logic [PC_W-1:0]  cur_rpc;
  logic [PC_W-1:0]  adv_pc;
  br_kind_e         kind;
  logic             push_nt, push_tk;
  logic [1:0]       push_cnt;
  logic [LANES-1:0] nt_mask, tk_mask;
  logic             br_go, fetch_go, stk_we;

  // Top-of-stack read: entry sp_q-1, zeros when empty.
  always_comb begin
    top_pc   = '0;
    cur_rpc  = '0;
    top_mask = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (int'(sp_q) == i + 1) begin
        top_pc   = pc_q[i];
        cur_rpc  = rpc_q[i];
        top_mask = mask_q[i];
      end
    end
  end

  assign live     = (sp_q != '0);
  assign ovf      = ovf_q;
  assign adv_pc   = top_pc + PC_W'(INSTR_BYTES);
  assign br_go    = br_en & live;
  assign fetch_go = fetch_en & live;
  assign stk_we   = launch_en | br_go | fetch_go;

  simt_pcs_br_sort #(
    .LANES (LANES),
    .PC_W  (PC_W)
  ) u_sort (
    .top_mask  (top_mask),
    .top_pc    (top_pc),
    .taken     (br_taken),
    .br_target (br_target),
    .br_rpc    (br_rpc),
    .kind      (kind),
    .push_nt   (push_nt),
    .push_tk   (push_tk),
    .push_cnt  (push_cnt),
    .nt_mask   (nt_mask),
    .tk_mask   (tk_mask)
  );

  // Next-state logic.
  always_comb begin
    pc_d   = pc_q;
    rpc_d  = rpc_q;
    mask_d = mask_q;
    sp_d   = sp_q;
    ovf_d  = ovf_q;
    if (launch_en) begin
      pc_d[0]   = launch_pc;
      rpc_d[0]  = launch_end;
      mask_d[0] = launch_mask;
      sp_d      = SP_W'(1);
    end else if (br_go) begin
      if (kind == BR_UNIFORM) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (int'(sp_q) == i + 1) pc_d[i] = br_target;
        end
      end else if (kind == BR_SPLIT) begin
        if (int'(sp_q) + int'(push_cnt) > DEPTH) begin
          ovf_d = 1'b1;
        end else begin
          for (int i = 0; i < DEPTH; i++) begin
            if (int'(sp_q) == i + 1) pc_d[i] = br_rpc;
            if (int'(sp_q) == i) begin
              if (push_nt) begin
                pc_d[i]   = top_pc;
                rpc_d[i]  = br_rpc;
                mask_d[i] = nt_mask;
              end else if (push_tk) begin
                pc_d[i]   = br_target;
                rpc_d[i]  = br_rpc;
                mask_d[i] = tk_mask;
              end
            end
            if ((int'(sp_q) + 1 == i) && push_nt && push_tk) begin
              pc_d[i]   = br_target;
              rpc_d[i]  = br_rpc;
              mask_d[i] = tk_mask;
            end
          end
          sp_d = sp_q + SP_W'(push_cnt);
        end
      end
    end else if (fetch_go) begin
      if (adv_pc == cur_rpc) begin
        sp_d = sp_q - SP_W'(1);
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (int'(sp_q) == i + 1) pc_d[i] = adv_pc;
        end
      end
    end
  end

  // Control state: reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (stk_we) sp_q <= sp_d;
      ovf_q <= ovf_d;
    end
  end

  // Stack storage: no reset, written under enable.
  always_ff @(posedge clk) begin
    if (stk_we) begin
      pc_q   <= pc_d;
      rpc_q  <= rpc_d;
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/simt_pcs_fetch_port.sv
module simt_pcs_fetch_port #(
  parameter int NUM_WARPS = 4,
  parameter int LANES     = 8,
  parameter int PC_W      = 32,
  parameter int WID_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go,
  input  logic [WID_W-1:0]           warp,
  input  logic [NUM_WARPS*PC_W-1:0]  tops_pc,
  input  logic [NUM_WARPS*LANES-1:0] tops_mask,
  output logic                       fetch_valid,
  output logic [PC_W-1:0]            fetch_pc,
  output logic [WID_W-1:0]           fetch_wid,
  output logic [LANES-1:0]           fetch_mask
);

  logic [PC_W-1:0]  sel_pc;
  logic [LANES-1:0] sel_mask;
  logic             valid_q;
  logic [PC_W-1:0]  pc_q;
  logic [WID_W-1:0] wid_q;
  logic [LANES-1:0] mask_q;

  always_comb begin
    sel_pc   = '0;
    sel_mask = '0;
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (int'(warp) == w) begin
        sel_pc   = tops_pc[w*PC_W +: PC_W];
        sel_mask = tops_mask[w*LANES +: LANES];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= go;
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      pc_q   <= sel_pc;
      wid_q  <= warp;
      mask_q <= sel_mask;
    end
  end

  assign fetch_valid = valid_q;
  assign fetch_pc    = pc_q;
  assign fetch_wid   = wid_q;
  assign fetch_mask  = mask_q;

endmodule

// File: rtl/simt_pc_stack.sv
module simt_pc_stack #(
  parameter int NUM_WARPS = 4,
  parameter int LANES     = 8,
  parameter int DEPTH     = 4,
  parameter int PC_W      = 32,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_valid,
  input  logic [WID_W-1:0]     launch_warp,
  input  logic [PC_W-1:0]      launch_pc,
  input  logic [PC_W-1:0]      launch_end_pc,
  input  logic [LANES-1:0]     launch_mask,
  input  logic                 fetch_req,
  input  logic [WID_W-1:0]     fetch_warp,
  input  logic                 br_valid,
  input  logic [WID_W-1:0]     br_warp,
  input  logic [PC_W-1:0]      br_target,
  input  logic [PC_W-1:0]      br_rpc,
  input  logic [LANES-1:0]     br_taken,
  output logic                 fetch_valid,
  output logic [PC_W-1:0]      fetch_pc,
  output logic [WID_W-1:0]     fetch_wid,
  output logic [LANES-1:0]     fetch_mask,
  output logic [NUM_WARPS-1:0] warp_live,
  output logic [NUM_WARPS-1:0] stack_ovf
);

  logic [NUM_WARPS*PC_W-1:0]  tops_pc;
  logic [NUM_WARPS*LANES-1:0] tops_mask;
  logic [NUM_WARPS-1:0]       fetch_sel;
  logic                       fetch_go;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic l_en, b_en, f_en;
    assign l_en = launch_valid && (int'(launch_warp) == w);
    assign b_en = br_valid && (int'(br_warp) == w) && !l_en;
    assign f_en = fetch_req && (int'(fetch_warp) == w) && !l_en
                  && !(br_valid && (int'(br_warp) == w));
    assign fetch_sel[w] = f_en & warp_live[w];

    simt_pcs_warp #(
      .LANES (LANES),
      .DEPTH (DEPTH),
      .PC_W  (PC_W)
    ) u_warp (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch_en   (l_en),
      .launch_pc   (launch_pc),
      .launch_end  (launch_end_pc),
      .launch_mask (launch_mask),
      .br_en       (b_en),
      .br_target   (br_target),
      .br_rpc      (br_rpc),
      .br_taken    (br_taken),
      .fetch_en    (f_en),
      .top_pc      (tops_pc[w*PC_W +: PC_W]),
      .top_mask    (tops_mask[w*LANES +: LANES]),
      .live        (warp_live[w]),
      .ovf         (stack_ovf[w])
    );
  end

  assign fetch_go = |fetch_sel;

  simt_pcs_fetch_port #(
    .NUM_WARPS (NUM_WARPS),
    .LANES     (LANES),
    .PC_W      (PC_W),
    .WID_W     (WID_W)
  ) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (fetch_go),
    .warp        (fetch_warp),
    .tops_pc     (tops_pc),
    .tops_mask   (tops_mask),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .fetch_wid   (fetch_wid),
    .fetch_mask  (fetch_mask)
  );

endmodule

// File: rtl/simt_pc_stack_chk.sv
module simt_pc_stack_chk #(
  parameter int NUM_WARPS = 4,
  parameter int LANES     = 8,
  parameter int WID_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 launch_valid,
  input logic [WID_W-1:0]     launch_warp,
  input logic                 fetch_req,
  input logic [WID_W-1:0]     fetch_warp,
  input logic                 br_valid,
  input logic [WID_W-1:0]     br_warp,
  input logic                 fetch_valid,
  input logic [WID_W-1:0]     fetch_wid,
  input logic [LANES-1:0]     fetch_mask,
  input logic [NUM_WARPS-1:0] warp_live,
  input logic [NUM_WARPS-1:0] stack_ovf
);

  // R3: an unobstructed fetch to a live warp answers on the next cycle with its ID.
  a_r3_fetch_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && warp_live[fetch_warp]
     && !(launch_valid && launch_warp == fetch_warp)
     && !(br_valid && br_warp == fetch_warp))
    |=> (fetch_valid && fetch_wid == $past(fetch_warp)));

  // R8: a fetch to a warp that is not live produces nothing.
  a_r8_dead_warp_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !warp_live[fetch_warp] && !launch_valid && !br_valid)
    |=> !fetch_valid);

  // R10: a branch for the fetched warp overrides the fetch.
  a_r10_branch_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && br_valid && br_warp == fetch_warp) |=> !fetch_valid);

  // R9: overflow flags never clear once set.
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stack_ovf & $past(stack_ovf)) == $past(stack_ovf)));

  // R2: a warp only becomes live through a launch.
  a_r2_live_from_launch: assert property (@(posedge clk) disable iff (!rst_n)
    ((warp_live & ~$past(warp_live)) != '0) |-> $past(launch_valid));

  // R12: a branch to a dead warp leaves it dead.
  a_r12_dead_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !warp_live[br_warp] && !launch_valid)
    |=> !warp_live[$past(br_warp)]);

  // R5: every fetched instruction carries at least one lane.
  a_r5_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (fetch_mask != '0));

endmodule

bind simt_pc_stack simt_pc_stack_chk #(
  .NUM_WARPS (NUM_WARPS),
  .LANES     (LANES),
  .WID_W     (WID_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .launch_valid (launch_valid),
  .launch_warp  (launch_warp),
  .fetch_req    (fetch_req),
  .fetch_warp   (fetch_warp),
  .br_valid     (br_valid),
  .br_warp      (br_warp),
  .fetch_valid  (fetch_valid),
  .fetch_wid    (fetch_wid),
  .fetch_mask   (fetch_mask),
  .warp_live    (warp_live),
  .stack_ovf    (stack_ovf)
);

// File: tb/sim_simt_pc_stack.sv
module sim_simt_pc_stack;

  localparam int NW = 4;
  localparam int LN = 8;
  localparam int DP = 4;
  localparam int PW = 32;
  localparam int WW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          launch_valid = 1'b0;
  logic [WW-1:0] launch_warp = '0;
  logic [PW-1:0] launch_pc = '0;
  logic [PW-1:0] launch_end_pc = '0;
  logic [LN-1:0] launch_mask = '0;
  logic          fetch_req = 1'b0;
  logic [WW-1:0] fetch_warp = '0;
  logic          br_valid = 1'b0;
  logic [WW-1:0] br_warp = '0;
  logic [PW-1:0] br_target = '0;
  logic [PW-1:0] br_rpc = '0;
  logic [LN-1:0] br_taken = '0;
  logic          fetch_valid;
  logic [PW-1:0] fetch_pc;
  logic [WW-1:0] fetch_wid;
  logic [LN-1:0] fetch_mask;
  logic [NW-1:0] warp_live;
  logic [NW-1:0] stack_ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  simt_pc_stack #(.NUM_WARPS(NW), .LANES(LN), .DEPTH(DP), .PC_W(PW)) u0 (.*);

  // Reference model: per-warp queues, back = top of stack.
  int unsigned   mpc   [NW][$];
  int unsigned   mrpc  [NW][$];
  logic [LN-1:0] mmask [NW][$];
  logic [NW-1:0] movf = '0;
  bit            e_valid = 0;
  int unsigned   e_pc = 0;
  int            e_wid = 0;
  logic [LN-1:0] e_mask = '0;

  function automatic logic [NW-1:0] mlive();
    logic [NW-1:0] v = '0;
    for (int w = 0; w < NW; w++) v[w] = (mpc[w].size() != 0);
    return v;
  endfunction

  task automatic model_step();
    int fw = int'(fetch_warp);
    int bw = int'(br_warp);
    int lw = int'(launch_warp);
    e_valid = 0;
    if (fetch_req && !(launch_valid && lw == fw) && !(br_valid && bw == fw)
        && mpc[fw].size() != 0) begin
      int n = mpc[fw].size();
      int unsigned adv = mpc[fw][n-1] + 8;
      e_valid = 1; e_pc = mpc[fw][n-1]; e_mask = mmask[fw][n-1]; e_wid = fw;
      if (adv == mrpc[fw][n-1]) begin
        void'(mpc[fw].pop_back()); void'(mrpc[fw].pop_back()); void'(mmask[fw].pop_back());
      end else mpc[fw][n-1] = adv;
    end
    if (br_valid && !(launch_valid && lw == bw) && mpc[bw].size() != 0) begin
      int n = mpc[bw].size();
      logic [LN-1:0] t  = mmask[bw][n-1];
      logic [LN-1:0] tk = t & br_taken;
      if (tk == '0) begin
      end else if (tk == t) begin
        mpc[bw][n-1] = br_target;
      end else begin
        int unsigned cur = mpc[bw][n-1];
        int need = ((cur != br_rpc) ? 1 : 0) + ((br_target != br_rpc) ? 1 : 0);
        if (n + need > DP) movf[bw] = 1'b1;
        else begin
          mpc[bw][n-1] = br_rpc;
          if (cur != br_rpc) begin
            mpc[bw].push_back(cur); mrpc[bw].push_back(br_rpc); mmask[bw].push_back(t & ~br_taken);
          end
          if (br_target != br_rpc) begin
            mpc[bw].push_back(br_target); mrpc[bw].push_back(br_rpc); mmask[bw].push_back(tk);
          end
        end
      end
    end
    if (launch_valid) begin
      mpc[lw].delete(); mrpc[lw].delete(); mmask[lw].delete();
      mpc[lw].push_back(launch_pc); mrpc[lw].push_back(launch_end_pc); mmask[lw].push_back(launch_mask);
    end
  endtask

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "fetch_valid", 64'(fetch_valid), 64'(e_valid));
    if (e_valid) begin
      chk(tag, "fetch_pc", 64'(fetch_pc), 64'(e_pc));
      chk(tag, "fetch_wid", 64'(fetch_wid), 64'(e_wid));
      chk(tag, "fetch_mask", 64'(fetch_mask), 64'(e_mask));
    end
    chk(tag, "warp_live", 64'(warp_live), 64'(mlive()));
    chk(tag, "stack_ovf", 64'(stack_ovf), 64'(movf));
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    compare(tag);
    launch_valid = 0; fetch_req = 0; br_valid = 0;
  endtask

  task automatic lau(int w, int unsigned pc, int unsigned ep, logic [LN-1:0] m);
    launch_valid = 1; launch_warp = WW'(w); launch_pc = pc; launch_end_pc = ep; launch_mask = m;
  endtask
  task automatic fet(int w);
    fetch_req = 1; fetch_warp = WW'(w);
  endtask
  task automatic brn(int w, int unsigned t, int unsigned r, logic [LN-1:0] tk);
    br_valid = 1; br_warp = WW'(w); br_target = t; br_rpc = r; br_taken = tk;
  endtask

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    @(negedge clk);
    compare("R1");
    cyc("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    fet(0); cyc("R1");

    // R2 / R3: launch and sequential fetch
    lau(0, 32'h100, 32'h200, 8'hFF); cyc("R2");
    for (int i = 0; i < 3; i++) begin fet(0); cyc("R3"); end
    lau(1, 32'h0, 32'h40, 8'h0F); cyc("R2");
    for (int i = 0; i < 4; i++) begin fet(i % 2); cyc("R11"); end

    // R5 / R7: divergence then reconvergence on warp 0
    brn(0, 32'h140, 32'h160, 8'h0F); cyc("R5");
    for (int i = 0; i < 16; i++) begin fet(0); cyc("R7"); end

    // R6 / R4 / R8 on warp 2
    lau(2, 32'h400, 32'h480, 8'hFF); cyc("R2");
    fet(2); cyc("R3");
    brn(2, 32'h420, 32'h420, 8'h0F); cyc("R6");
    for (int i = 0; i < 4; i++) begin fet(2); cyc("R6"); end
    brn(2, 32'h460, 32'h500, 8'hFF); cyc("R4");
    fet(2); cyc("R4");
    brn(2, 32'h700, 32'h500, 8'h00); cyc("R4");
    for (int i = 0; i < 3; i++) begin fet(2); cyc("R8"); end
    fet(2); cyc("R8");
    brn(2, 32'h10, 32'h20, 8'h01); cyc("R12");
    fet(2); cyc("R12");

    // R9: fill exactly, then overflow, on warp 3
    lau(3, 32'h800, 32'h900, 8'hFF); cyc("R2");
    brn(3, 32'h840, 32'h880, 8'h0F); cyc("R9");
    brn(3, 32'h848, 32'h848, 8'h01); cyc("R9");
    brn(3, 32'h900, 32'h908, 8'h02); cyc("R9");
    for (int i = 0; i < 4; i++) begin fet(3); cyc("R9"); end

    // R10: priorities on one warp
    fet(0); brn(0, 32'h300, 32'h300, 8'hFF); cyc("R10");
    fet(0); cyc("R10");
    fet(1); lau(1, 32'h40, 32'h80, 8'h3C); brn(1, 32'h0, 32'h0, 8'hFF); cyc("R10");
    fet(1); cyc("R10");
    lau(2, 32'h600, 32'h640, 8'hA5); fet(0); cyc("R2");

    // R11: mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0)
        lau(int'(lfsr[4:3]), {20'h0, lfsr[11:5], 5'h0}, {20'h0, lfsr[11:5], 5'h0} + 32'h40,
            8'(lfsr[15:8]) | 8'h01);
      if (lfsr[5:3] != 3'd1) fet(int'(lfsr[7:6]));
      if (lfsr[10:8] == 3'd3) begin
        int unsigned cur = 0;
        int bw = int'(lfsr[12:11]);
        if (mpc[bw].size() != 0) cur = mpc[bw][mpc[bw].size()-1];
        brn(bw, cur + {28'h0, lfsr[14:13], 3'h0}, cur + 32'h20, 8'(lfsr[15:8]));
      end
      cyc("R11");
    end

    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule